// File: doc/BRIEF.md
# Output Routing Pool Slice Array

This block connects the sixteen macrocells of a logic block to the pins of one I/O block. Each pin has its own slice. A slice picks one macrocell from a window of eight candidates. The window slides with the slice index and wraps modulo 16. How far it moves from one slice to the next depends on how many pins the block serves: 8, 12 or 16. The output-enable product term of the chosen macrocell is steered with its data, so an output keeps its enable when it moves to a different pin.

A second multiplexer in each slice can bypass the routing. It drives the pin from the home macrocell of the slice, which is the first macrocell of the window. The source is the fast five-product-term path (true or inverted) or the register output of that macrocell. In these modes the enable comes from the home macrocell's OE term. All selections are static configuration inputs. The block has no storage, so the pins follow their inputs within the same cycle.

Top module: `orp_slice_array`

## Requirements
- R1: With 16 pins, a route code k on slice s selects macrocell (s+k) mod 16. The route code is 3 bits per slice, at bits [3s+2:3s] of `cfg_route_sel`.
- R2: With 8 pins, route code k on slice s selects macrocell (2s+k) mod 16.
- R3: With 12 pins, the window bases for slices 0 to 11 are 0,1,2,4,5,6,8,9,10,12,13,14. Route code k selects macrocell (base+k) mod 16.
- R4: In routed mode, `pin_oe` of a slice equals the OE term of the same macrocell that drives its `pin_data`. Routed mode is path code 0. The path code is 2 bits per slice, at bits [2s+1:2s] of `cfg_path_sel`.
- R5: Path code 1 drives the pin from `fast_pt` of the home macrocell. Path code 2 drives its inverse. Path code 3 drives `mc_reg` of the home macrocell. The home macrocell is the window base.
- R6: For path codes 1, 2 and 3, `pin_oe` equals `mc_oe` of the home macrocell.
- R7: For path codes 1, 2 and 3, the slice's route code has no effect on `pin_data` or `pin_oe`.
- R8: Each slice follows only its own route and path fields. Slices with different path codes at the same time each give their own result.
- R9: The outputs depend only on the present inputs and settle in the same cycle the inputs change. No register sits between inputs and pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mc_out | input | N_MC | Combinational output of each macrocell |
| mc_oe | input | N_MC | Output-enable product term of each macrocell |
| fast_pt | input | N_MC | Fast five-product-term path of each macrocell |
| mc_reg | input | N_MC | Register output of each macrocell |
| cfg_route_sel | input | N_IO*3 | Per-slice window offset |
| cfg_path_sel | input | N_IO*2 | Per-slice source select: 0 routed, 1 fast, 2 fast inverted, 3 register |
| pin_data | output | N_IO | Data to each I/O cell |
| pin_oe | output | N_IO | Output enable to each I/O cell |

## Verification
The bench builds three copies of the block side by side, with N_IO set to 16, 12 and 8. All three get the same macrocell vectors and configuration fields. This means one walking-one pattern tests the three window shapes at once, including where the windows wrap past macrocell 15. With 12 pins the skipped bases (3, 7, 11, 15) become visible, and with 8 pins the stride of two and the fact that odd macrocells are never home both become visible. Mixed per-slice path codes on every copy check that the slices stay independent for each pin count.

// File: rtl/orp_pkg.sv
package orp_pkg;

    typedef enum logic [1:0] {
        PATH_ROUTED   = 2'd0,
        PATH_FAST     = 2'd1,
        PATH_FAST_INV = 2'd2,
        PATH_REG      = 2'd3
    } path_sel_e;

    // First macrocell of the candidate window for a given slice
    function automatic int unsigned win_base(input int unsigned n_io, input int unsigned slice);
        case (n_io)
            8:       return slice * 2;
            12:      return slice + slice / 3;
            default: return slice;
        endcase
    endfunction

endpackage

// File: rtl/orp_route_mux.sv
module orp_route_mux #(
    parameter int WIN   = 8,
    parameter int SEL_W = $clog2(WIN)
) (
    input  logic [WIN-1:0]   cand_data,
    input  logic [WIN-1:0]   cand_oe,
    input  logic [SEL_W-1:0] sel,
    output logic             routed_data,
    output logic             routed_oe
);

    // Data and enable share one select so the OE term tracks its output
    always_comb begin
        routed_data = cand_data[sel];
        routed_oe   = cand_oe[sel];
    end

endmodule

// File: rtl/orp_bypass_mux.sv
module orp_bypass_mux
    import orp_pkg::*;
(
    input  path_sel_e path_sel,
    input  logic      routed_data,
    input  logic      routed_oe,
    input  logic      home_fast,
    input  logic      home_reg,
    input  logic      home_oe,
    output logic      pin_data,
    output logic      pin_oe
);

    always_comb begin
        unique case (path_sel)
            PATH_ROUTED: begin
                pin_data = routed_data;
                pin_oe   = routed_oe;
            end
            PATH_FAST: begin
                pin_data = home_fast;
                pin_oe   = home_oe;
            end
            PATH_FAST_INV: begin
                pin_data = ~home_fast;
                pin_oe   = home_oe;
            end
            PATH_REG: begin
                pin_data = home_reg;
                pin_oe   = home_oe;
            end
            default: begin
                pin_data = routed_data;
                pin_oe   = routed_oe;
            end
        endcase
    end

endmodule

// File: rtl/orp_slice_array.sv
module orp_slice_array
    import orp_pkg::*;
#(
    parameter int N_IO  = 16,
    parameter int N_MC  = 16,
    parameter int WIN   = 8,
    parameter int SEL_W = $clog2(WIN)
) (
    input  logic [N_MC-1:0]       mc_out,
    input  logic [N_MC-1:0]       mc_oe,
    input  logic [N_MC-1:0]       fast_pt,
    input  logic [N_MC-1:0]       mc_reg,
    input  logic [N_IO*SEL_W-1:0] cfg_route_sel,
    input  logic [N_IO*2-1:0]     cfg_path_sel,
    output logic [N_IO-1:0]       pin_data,
    output logic [N_IO-1:0]       pin_oe
);

    for (genvar s = 0; s < N_IO; s++) begin : g_slice
        localparam int unsigned HOME = win_base(N_IO, s) % N_MC;

        logic [WIN-1:0] cand_data;
        logic [WIN-1:0] cand_oe;
        logic           routed_data;
        logic           routed_oe;

        for (genvar k = 0; k < WIN; k++) begin : g_cand
            assign cand_data[k] = mc_out[(HOME + k) % N_MC];
            assign cand_oe[k]   = mc_oe[(HOME + k) % N_MC];
        end

        orp_route_mux #(
            .WIN   (WIN),
            .SEL_W (SEL_W)
        ) u_route (
            .cand_data   (cand_data),
            .cand_oe     (cand_oe),
            .sel         (cfg_route_sel[SEL_W*s +: SEL_W]),
            .routed_data (routed_data),
            .routed_oe   (routed_oe)
        );

        orp_bypass_mux u_bypass (
            .path_sel    (path_sel_e'(cfg_path_sel[2*s +: 2])),
            .routed_data (routed_data),
            .routed_oe   (routed_oe),
            .home_fast   (fast_pt[HOME]),
            .home_reg    (mc_reg[HOME]),
            .home_oe     (mc_oe[HOME]),
            .pin_data    (pin_data[s]),
            .pin_oe      (pin_oe[s])
        );
    end

endmodule

// File: rtl/orp_slice_array_chk.sv
module orp_slice_array_chk #(
    parameter int N_IO  = 16,
    parameter int N_MC  = 16,
    parameter int WIN   = 8,
    parameter int SEL_W = $clog2(WIN),
    parameter int MC_W  = $clog2(N_MC)
) (
    input logic [N_MC-1:0]       mc_out,
    input logic [N_MC-1:0]       mc_oe,
    input logic [N_MC-1:0]       fast_pt,
    input logic [N_MC-1:0]       mc_reg,
    input logic [N_IO*SEL_W-1:0] cfg_route_sel,
    input logic [N_IO*2-1:0]     cfg_path_sel,
    input logic [N_IO-1:0]       pin_data,
    input logic [N_IO-1:0]       pin_oe
);

    // Independent window model: groups of three slices advance by four
    function automatic int home_of(input int s);
        if (N_IO == 8)  return 2 * s;
        if (N_IO == 12) return (s / 3) * 4 + (s % 3);
        return s;
    endfunction

    logic              known;
    logic [MC_W-1:0]   h_i;
    logic [MC_W-1:0]   m_i;
    logic [1:0]        p_i;

    always_comb begin
        known = !$isunknown({mc_out, mc_oe, fast_pt, mc_reg, cfg_route_sel, cfg_path_sel, pin_data, pin_oe});
        h_i = '0;
        m_i = '0;
        p_i = '0;
        if (known) begin
            for (int s = 0; s < N_IO; s++) begin
                h_i = MC_W'(home_of(s) % N_MC);
                m_i = MC_W'((home_of(s) + int'(cfg_route_sel[SEL_W*s +: SEL_W])) % N_MC);
                p_i = cfg_path_sel[2*s +: 2];
                if (p_i == 2'd0) begin
                    if (N_IO == 8) begin
                        AST_WIN8_DATA: assert (pin_data[s] == mc_out[m_i]) else $error("win8 slice %0d", s); // R2
                    end else if (N_IO == 12) begin
                        AST_WIN12_DATA: assert (pin_data[s] == mc_out[m_i]) else $error("win12 slice %0d", s); // R3
                    end else begin
                        AST_WIN16_DATA: assert (pin_data[s] == mc_out[m_i]) else $error("win16 slice %0d", s); // R1
                    end
                    AST_ROUTED_OE: assert (pin_oe[s] == mc_oe[m_i]) else $error("oe slice %0d", s); // R4
                end else begin
                    AST_BYPASS_OE: assert (pin_oe[s] == mc_oe[h_i]) else $error("byp oe slice %0d", s); // R6
                    if (p_i == 2'd1) begin
                        AST_FAST_TRUE: assert (pin_data[s] == fast_pt[h_i]) else $error("fast slice %0d", s); // R5
                    end else if (p_i == 2'd2) begin
                        AST_FAST_INV: assert (pin_data[s] != fast_pt[h_i]) else $error("fastn slice %0d", s); // R5
                    end else begin
                        AST_REG_DIRECT: assert (pin_data[s] == mc_reg[h_i]) else $error("reg slice %0d", s); // R5
                    end
                end
            end
        end
    end

endmodule

bind orp_slice_array orp_slice_array_chk #(
    .N_IO  (N_IO),
    .N_MC  (N_MC),
    .WIN   (WIN),
    .SEL_W (SEL_W)
) u_chk (
    .mc_out        (mc_out),
    .mc_oe         (mc_oe),
    .fast_pt       (fast_pt),
    .mc_reg        (mc_reg),
    .cfg_route_sel (cfg_route_sel),
    .cfg_path_sel  (cfg_path_sel),
    .pin_data      (pin_data),
    .pin_oe        (pin_oe)
);

// File: tb/orp_slice_array_bench.sv
module orp_slice_array_bench;

    typedef struct {
        int          nio;
        logic [15:0] d;
        logic [15:0] o;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mcd = '0;
    logic [15:0] mco = '0;
    logic [15:0] fpt = '0;
    logic [15:0] rgq = '0;
    logic [47:0] cr  = '0;
    logic [31:0] cp  = '0;

    logic [15:0] pd16, po16;
    logic [11:0] pd12, po12;
    logic [7:0]  pd8,  po8;

    exp_t sbq[$];
    exp_t cur;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    orp_slice_array #(.N_IO(16)) u_orp_slice_array (
        .mc_out(mcd), .mc_oe(mco), .fast_pt(fpt), .mc_reg(rgq),
        .cfg_route_sel(cr), .cfg_path_sel(cp), .pin_data(pd16), .pin_oe(po16)
    );
    orp_slice_array #(.N_IO(12)) u_orp_slice_array_12 (
        .mc_out(mcd), .mc_oe(mco), .fast_pt(fpt), .mc_reg(rgq),
        .cfg_route_sel(cr[35:0]), .cfg_path_sel(cp[23:0]), .pin_data(pd12), .pin_oe(po12)
    );
    orp_slice_array #(.N_IO(8)) u_orp_slice_array_8 (
        .mc_out(mcd), .mc_oe(mco), .fast_pt(fpt), .mc_reg(rgq),
        .cfg_route_sel(cr[23:0]), .cfg_path_sel(cp[15:0]), .pin_data(pd8), .pin_oe(po8)
    );

    function automatic int ref_base(input int nio, input int s);
        if (nio == 8)  return 2 * s;
        if (nio == 12) return (s / 3) * 4 + (s % 3);
        return s;
    endfunction

    // Driver: applies one stimulus and queues the expected pins of all three copies.
    // pm 0..3 = same path code on every slice, pm >= 4 = mixed codes per slice (R8).
    task automatic drive(input string req, input logic [15:0] d, input logic [15:0] o,
                         input logic [15:0] f, input logic [15:0] r, input int rot, input int pm);
        exp_t e;
        @(posedge clk);
        #1;
        mcd = d; mco = o; fpt = f; rgq = r;
        for (int s = 0; s < 16; s++) begin
            cr[3*s +: 3] = 3'((s * 3 + rot) % 8);
            cp[2*s +: 2] = 2'((pm < 4) ? pm : (s + pm) % 4);
        end
        for (int w = 0; w < 3; w++) begin
            e.nio = (w == 0) ? 16 : (w == 1) ? 12 : 8;
            e.d = '0;
            e.o = '0;
            if (req == "WIN") e.req = (e.nio == 16) ? "R1" : (e.nio == 12) ? "R3" : "R2";
            else              e.req = req;
            for (int s = 0; s < e.nio; s++) begin
                int h;
                int m;
                int p;
                h = ref_base(e.nio, s) % 16;
                m = (h + (s * 3 + rot) % 8) % 16;
                p = (pm < 4) ? pm : (s + pm) % 4;
                case (p)
                    0:       begin e.d[s] = d[m];  e.o[s] = o[m]; end
                    1:       begin e.d[s] = f[h];  e.o[s] = o[h]; end
                    2:       begin e.d[s] = ~f[h]; e.o[s] = o[h]; end
                    default: begin e.d[s] = r[h];  e.o[s] = o[h]; end
                endcase
            end
            sbq.push_back(e);
        end
    endtask

    // Monitor: pops expectations half a cycle after the drive
    always @(negedge clk) begin
        if (rst_n) begin
            while (sbq.size() > 0) begin
                logic [15:0] ad;
                logic [15:0] ao;
                cur = sbq.pop_front();
                if (cur.nio == 16)      begin ad = pd16;          ao = po16; end
                else if (cur.nio == 12) begin ad = {4'h0, pd12};  ao = {4'h0, po12}; end
                else                    begin ad = {8'h00, pd8};  ao = {8'h00, po8}; end
                n_checks++;
                if (ad !== cur.d || ao !== cur.o) begin
                    n_fail++;
                    $display("FAIL %s n_io=%0d data=%h exp=%h oe=%h exp=%h",
                             cur.req, cur.nio, ad, cur.d, ao, cur.o);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // all-zero inputs after reset: every pin quiet (R1 idle case)
        drive("R1", 16'h0, 16'h0, 16'h0, 16'h0, 0, 0);
        // R1 R2 R3: walking one on data through every window offset, incl. wrap
        for (int m = 0; m < 16; m++)
            for (int rot = 0; rot < 8; rot++)
                drive("WIN", 16'h1 << m, 16'h0, 16'h0, 16'h0, rot, 0);
        // R4: walking one on the OE terms, enable follows the routed macrocell
        for (int m = 0; m < 16; m++)
            for (int rot = 0; rot < 8; rot += 3)
                drive("R4", 16'hA5A5, 16'h1 << m, 16'h0, 16'h0, rot, 0);
        // R5: fast, inverted fast and register paths from the home macrocell
        for (int m = 0; m < 16; m++) begin
            drive("R5", 16'hFFFF, 16'h0, 16'h1 << m, 16'h0, 2, 1);
            drive("R5", 16'hFFFF, 16'h0, 16'h1 << m, 16'h0, 5, 2);
            drive("R5", 16'h0000, 16'h0, 16'hFFFF, 16'h1 << m, 1, 3);
        end
        // R6: enable in bypass modes comes from the home macrocell
        for (int m = 0; m < 16; m++)
            for (int pm = 1; pm < 4; pm++)
                drive("R6", 16'h5A5A, 16'h1 << m, 16'h3C3C, 16'hC3C3, m % 8, pm);
        // R7: route code changes while bypassed leave pins unchanged
        for (int pm = 1; pm < 4; pm++)
            for (int rot = 0; rot < 8; rot++)
                drive("R7", 16'h1234, 16'h8421, 16'h0F0F, 16'hF00F, rot, pm);
        // R8: mixed path codes across slices
        pat = 16'hACE1;
        for (int i = 0; i < 64; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
            a = pat;
            b = {pat[7:0], pat[15:8]} ^ 16'h5555;
            drive("R8", a, b, ~a, a ^ b, i % 8, 4 + (i % 4));
        end
        // R9: back-to-back changes, each visible within the same cycle
        for (int i = 0; i < 8; i++)
            drive("R9", (i % 2 == 0) ? 16'hFFFF : 16'h0000, (i % 2 == 0) ? 16'h0000 : 16'hFFFF,
                  16'h0, 16'h0, i, 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule